// File: doc/BRIEF.md
# Segment Register with Descriptor Cache

This block holds a single segment register: a 16-bit visible selector plus a hidden cache of base address, limit and attribute bits. A selector load fills the cache. In real mode the base comes straight from the selector, and the limit is a fixed 64 KiB. In protected mode the surrounding logic fetches the 64-bit descriptor and presents it with the selector. The block then unpacks the scattered base, limit and attribute fields into the cache.

Every memory access is translated from the cache alone, never from the selector. The block adds the offset to the cached base and checks the access against the cached limit and attributes. One cycle later it returns the linear address with separate limit and type fault flags. The mode input does not touch the cache. A segment loaded in protected mode therefore keeps its base and limit after a switch to real mode, until the selector is loaded again.

Top module: `seg_cache`

## Requirements
- R1: After reset the selector and base are 0, the effective limit is 0x0000FFFF, the attribute byte is 0x93 (P=1, DPL=0, S=1, type=0011), and the flag nibble is 0.
- R2: A load with `prot_mode`=0 sets the base to the selector times 16, the limit to 0x0000FFFF, the attributes to 0x93 and the flags to 0, and never raises `np_fault`.
- R3: A load with `prot_mode`=1 and descriptor bit 47 (P) set caches base = {d[63:56], d[39:32], d[31:16]}, raw limit = {d[51:48], d[15:0]}, attributes = {P d[47], DPL d[46:45], S d[44], type d[43:40]} and flags = {G d[55], D d[54], L d[53], AVL d[52]}.
- R4: When G is 1 the effective limit is {raw limit, 12'hFFF}; when G is 0 it is the raw limit zero-extended.
- R5: A protected-mode load with P=0 pulses `np_fault` in the cycle after the load and leaves selector, base, limit, attributes and flags unchanged.
- R6: An access request gives `acc_done` one cycle later, with `lin_addr` = cached base + offset modulo 2^32.
- R7: `lim_fault` is set when offset + `acc_last` (the byte count minus one) is greater than the effective limit, computed without overflow. An access that ends exactly at the limit passes.
- R8: In protected mode `type_fault` is set for a write to a code segment (type bit 3 = 1), a write to a data segment with type bit 1 = 0, a read of a code segment with type bit 1 = 0, or any access to a system segment (S=0).
- R9: In real mode `type_fault` is never set. The limit check still applies to the cached limit.
- R10: A change of `prot_mode` with no load leaves the cache unchanged, and later accesses use the cached base and limit.
- R11: `lim_fault` and `type_fault` are only set together with `acc_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_mode | input | 1 | 1 = protected mode, 0 = real mode |
| load_valid | input | 1 | Load selector (and descriptor) this cycle |
| load_sel | input | 16 | Selector to load |
| load_desc | input | 64 | Descriptor fetched for the selector (protected mode) |
| acc_valid | input | 1 | Access request |
| acc_offset | input | 32 | Effective address of the operand |
| acc_last | input | 3 | Access size in bytes minus one |
| acc_write | input | 1 | 1 = write, 0 = read |
| sel_out | output | 16 | Visible selector |
| base_out | output | 32 | Cached base |
| limit_out | output | 32 | Effective limit after granularity scaling |
| attr_out | output | 8 | Cached P, DPL, S, type |
| flags_out | output | 4 | Cached G, D, L, AVL |
| np_fault | output | 1 | Not-present descriptor load, one-cycle pulse |
| acc_done | output | 1 | Access result valid |
| lin_addr | output | 32 | Translated linear address |
| lim_fault | output | 1 | Limit violation |
| type_fault | output | 1 | Access-type violation |

## Verification
The cache registers are visible at the ports, so a wrong bit in any unpacked field shows up in the cycle right after the load. Each descriptor pattern places distinct values in every field to catch swapped or shifted slices. A cache that drifts or is rewritten on a mode switch shows up as a changed base or limit on the next translation. That translation is checked at the block's outputs one cycle after the request. Limits are checked at the exact boundary and one byte past it, so off-by-one errors in the comparison show up as a flipped `lim_fault` on that access.

// File: rtl/seg_cache.sv
module seg_cache #(
  parameter int AW  = 32,
  parameter int SW  = 16,
  parameter int LW  = 20,
  parameter int SZW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           prot_mode,
  input  logic           load_valid,
  input  logic [SW-1:0]  load_sel,
  input  logic [63:0]    load_desc,
  input  logic           acc_valid,
  input  logic [AW-1:0]  acc_offset,
  input  logic [SZW-1:0] acc_last,
  input  logic           acc_write,
  output logic [SW-1:0]  sel_out,
  output logic [AW-1:0]  base_out,
  output logic [AW-1:0]  limit_out,
  output logic [7:0]     attr_out,
  output logic [3:0]     flags_out,
  output logic           np_fault,
  output logic           acc_done,
  output logic [AW-1:0]  lin_addr,
  output logic           lim_fault,
  output logic           type_fault
);
  localparam int GS = 12;
  localparam logic [7:0]    REAL_ATTR = 8'h93;
  localparam logic [LW-1:0] REAL_LIM  = LW'(16'hFFFF);

  logic [SW-1:0]  sel_q;
  logic [AW-1:0]  base_q;
  logic [LW-1:0]  lim_q;
  logic [7:0]     attr_q;
  logic [3:0]     flg_q;

  wire [AW-1:0] d_base = AW'({load_desc[63:56], load_desc[39:32], load_desc[31:16]});
  wire [LW-1:0] d_lim  = LW'({load_desc[51:48], load_desc[15:0]});
  wire [7:0]    d_attr = load_desc[47:40];
  wire [3:0]    d_flg  = load_desc[55:52];
  wire          d_pres = load_desc[47];

  wire do_real = load_valid && !prot_mode;
  wire do_prot = load_valid && prot_mode && d_pres;
  wire do_np   = load_valid && prot_mode && !d_pres;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      base_q <= '0;
      lim_q  <= REAL_LIM;
      attr_q <= REAL_ATTR;
      flg_q  <= '0;
    end else if (do_real) begin
      sel_q  <= load_sel;
      base_q <= AW'({load_sel, 4'h0});
      lim_q  <= REAL_LIM;
      attr_q <= REAL_ATTR;
      flg_q  <= '0;
    end else if (do_prot) begin
      sel_q  <= load_sel;
      base_q <= d_base;
      lim_q  <= d_lim;
      attr_q <= d_attr;
      flg_q  <= d_flg;
    end
  end

  wire [AW-1:0] eff_lim = flg_q[3] ? AW'({lim_q, {GS{1'b1}}}) : AW'(lim_q);

  wire [AW:0] acc_end = {1'b0, acc_offset} + (AW+1)'(acc_last);
  wire        over    = acc_end > {1'b0, eff_lim};

  wire is_sys  = !attr_q[4];
  wire is_code = attr_q[3];
  wire rw_bit  = attr_q[1];
  wire bad_typ = is_sys
              || (acc_write && is_code)
              || (acc_write && !is_code && !rw_bit)
              || (!acc_write && is_code && !rw_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      np_fault   <= 1'b0;
      acc_done   <= 1'b0;
      lin_addr   <= '0;
      lim_fault  <= 1'b0;
      type_fault <= 1'b0;
    end else begin
      np_fault   <= do_np;
      acc_done   <= acc_valid;
      lin_addr   <= acc_valid ? base_q + acc_offset : lin_addr;
      lim_fault  <= acc_valid && over;
      type_fault <= acc_valid && prot_mode && bad_typ;
    end
  end

  assign sel_out   = sel_q;
  assign base_out  = base_q;
  assign limit_out = eff_lim;
  assign attr_out  = attr_q;
  assign flags_out = flg_q;
endmodule

// File: rtl/seg_cache_chk.sv
module seg_cache_chk #(
  parameter int AW = 32,
  parameter int SW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          prot_mode,
  input logic          load_valid,
  input logic [SW-1:0] load_sel,
  input logic [63:0]   load_desc,
  input logic          acc_valid,
  input logic [AW-1:0] base_out,
  input logic [AW-1:0] limit_out,
  input logic [SW-1:0] sel_out,
  input logic [7:0]    attr_out,
  input logic          np_fault,
  input logic          acc_done,
  input logic          lim_fault,
  input logic          type_fault
);
  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> acc_done); // R6
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !acc_done); // R6
  AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_fault || type_fault) |-> acc_done); // R11
  AST_REAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && !prot_mode) |=> (base_out == AW'({$past(load_sel), 4'h0}))
      && (limit_out == AW'(32'hFFFF)) && !np_fault); // R2
  AST_NP_KEEPS_CACHE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && prot_mode && !load_desc[47]) |=> np_fault && $stable(base_out)
      && $stable(limit_out) && $stable(sel_out) && $stable(attr_out)); // R5
  AST_CACHE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !load_valid |=> $stable(base_out) && $stable(limit_out) && $stable(sel_out)
      && $stable(attr_out)); // R10
  AST_REAL_NO_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !prot_mode) |=> !type_fault); // R9
endmodule

bind seg_cache seg_cache_chk #(.AW(AW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .prot_mode(prot_mode), .load_valid(load_valid),
  .load_sel(load_sel), .load_desc(load_desc), .acc_valid(acc_valid),
  .base_out(base_out), .limit_out(limit_out), .sel_out(sel_out),
  .attr_out(attr_out), .np_fault(np_fault), .acc_done(acc_done),
  .lim_fault(lim_fault), .type_fault(type_fault)
);

// File: tb/tb_seg_cache.sv
`timescale 1ns/1ps
module tb_seg_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prot_mode = 1'b0;
  logic        load_valid = 1'b0;
  logic [15:0] load_sel = '0;
  logic [63:0] load_desc = '0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_offset = '0;
  logic [2:0]  acc_last = '0;
  logic        acc_write = 1'b0;
  logic [15:0] sel_out;
  logic [31:0] base_out, limit_out, lin_addr;
  logic [7:0]  attr_out;
  logic [3:0]  flags_out;
  logic        np_fault, acc_done, lim_fault, type_fault;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  seg_cache dut (.*);

  function automatic logic [63:0] mk(input logic [31:0] b, input logic [19:0] l,
      input logic [3:0] typ, input logic s, input logic [1:0] dpl, input logic p,
      input logic [3:0] flg);
    logic [63:0] d;
    d = '0;
    d[15:0] = l[15:0];   d[31:16] = b[15:0];  d[39:32] = b[23:16];
    d[43:40] = typ;      d[44] = s;           d[46:45] = dpl;
    d[47] = p;           d[51:48] = l[19:16]; d[55:52] = flg;
    d[63:56] = b[31:24];
    return d;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic load(input logic mode, input logic [15:0] s, input logic [63:0] d);
    @(negedge clk);
    prot_mode = mode; load_valid = 1'b1; load_sel = s; load_desc = d;
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  task automatic access(input logic [31:0] off, input logic [2:0] last, input logic wr);
    @(negedge clk);
    acc_valid = 1'b1; acc_offset = off; acc_last = last; acc_write = wr;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "sel", sel_out, 16'h0);
    chk("R1", "base", base_out, 32'h0);
    chk("R1", "limit", limit_out, 32'hFFFF);
    chk("R1", "attr", attr_out, 8'h93);
    chk("R1", "flags", flags_out, 4'h0);
  endtask

  task automatic t_real;
    load(1'b0, 16'h1234, '1);
    chk("R2", "base", base_out, 32'h12340);
    chk("R2", "limit", limit_out, 32'hFFFF);
    chk("R2", "attr", attr_out, 8'h93);
    chk("R2", "np", np_fault, 1'b0);
    access(32'h10, 3'd1, 1'b1);
    chk("R6", "lin real", lin_addr, 32'h12350);
    chk("R6", "done", acc_done, 1'b1);
    chk("R7", "lim ok", lim_fault, 1'b0);
    access(32'hFFFF, 3'd0, 1'b0);
    chk("R7", "end at limit", lim_fault, 1'b0);
    access(32'hFFFF, 3'd1, 1'b0);
    chk("R7", "past limit real", lim_fault, 1'b1);
    chk("R9", "no type real", type_fault, 1'b0);
  endtask

  task automatic t_prot;
    load(1'b1, 16'h0018, mk(32'h12345678, 20'hABCDE, 4'hA, 1'b1, 2'd2, 1'b1, 4'h5));
    chk("R3", "sel", sel_out, 16'h0018);
    chk("R3", "base", base_out, 32'h12345678);
    chk("R3", "limit", limit_out, 32'h000ABCDE);
    chk("R3", "attr", attr_out, 8'hDA);
    chk("R3", "flags", flags_out, 4'h5);
    access(32'hABCDE, 3'd0, 1'b0);
    chk("R6", "lin prot", lin_addr, 32'h12345678 + 32'hABCDE);
    chk("R7", "at limit", lim_fault, 1'b0);
    chk("R8", "read code ok", type_fault, 1'b0);
    access(32'hABCDE, 3'd1, 1'b0);
    chk("R7", "past limit", lim_fault, 1'b1);
    access(32'h0, 3'd0, 1'b1);
    chk("R8", "write code", type_fault, 1'b1);
    chk("R11", "no lim", lim_fault, 1'b0);
  endtask

  task automatic t_gran;
    load(1'b1, 16'h0020, mk(32'h0, 20'h00001, 4'h2, 1'b1, 2'd0, 1'b1, 4'h8));
    chk("R4", "G limit", limit_out, 32'h1FFF);
    access(32'h1FFC, 3'd3, 1'b1);
    chk("R4", "G at limit", lim_fault, 1'b0);
    chk("R8", "write data rw", type_fault, 1'b0);
    access(32'h1FFD, 3'd3, 1'b1);
    chk("R4", "G past limit", lim_fault, 1'b1);
  endtask

  task automatic t_types;
    load(1'b1, 16'h0028, mk(32'h1000, 20'hFFFF, 4'h0, 1'b1, 2'd0, 1'b1, 4'h0));
    access(32'h4, 3'd0, 1'b1);
    chk("R8", "write read-only", type_fault, 1'b1);
    access(32'h4, 3'd0, 1'b0);
    chk("R8", "read read-only", type_fault, 1'b0);
    load(1'b1, 16'h0030, mk(32'h1000, 20'hFFFF, 4'h8, 1'b1, 2'd0, 1'b1, 4'h0));
    access(32'h4, 3'd0, 1'b0);
    chk("R8", "read exec-only", type_fault, 1'b1);
    load(1'b1, 16'h0038, mk(32'h1000, 20'hFFFF, 4'h2, 1'b0, 2'd0, 1'b1, 4'h0));
    access(32'h4, 3'd0, 1'b0);
    chk("R8", "system seg", type_fault, 1'b1);
  endtask

  task automatic t_np;
    load(1'b1, 16'h0040, mk(32'h00400000, 20'hFFFFF, 4'h0, 1'b1, 2'd0, 1'b1, 4'h0));
    @(negedge clk);
    prot_mode = 1'b1; load_valid = 1'b1; load_sel = 16'h0048;
    load_desc = mk(32'h0BAD0000, 20'h1, 4'h2, 1'b1, 2'd0, 1'b0, 4'h8);
    @(negedge clk);
    load_valid = 1'b0;
    chk("R5", "np pulse", np_fault, 1'b1);
    chk("R5", "sel kept", sel_out, 16'h0040);
    chk("R5", "base kept", base_out, 32'h00400000);
    chk("R5", "limit kept", limit_out, 32'h000FFFFF);
    chk("R5", "attr kept", attr_out, 8'h90);
    @(negedge clk);
    chk("R5", "np single", np_fault, 1'b0);
  endtask

  task automatic t_mode;
    @(negedge clk);
    prot_mode = 1'b0;
    @(negedge clk);
    chk("R10", "base after switch", base_out, 32'h00400000);
    chk("R10", "limit after switch", limit_out, 32'h000FFFFF);
    access(32'h00020000, 3'd0, 1'b1);
    chk("R10", "lin uses cache", lin_addr, 32'h00420000);
    chk("R10", "big limit kept", lim_fault, 1'b0);
    chk("R9", "write ro in real", type_fault, 1'b0);
    access(32'h00100000, 3'd0, 1'b0);
    chk("R9", "limit in real", lim_fault, 1'b1);
  endtask

  task automatic t_wrap;
    load(1'b1, 16'h0050, mk(32'hFFFFFFF0, 20'hFFFFF, 4'h2, 1'b1, 2'd0, 1'b1, 4'h8));
    access(32'h20, 3'd0, 1'b0);
    chk("R6", "wrap", lin_addr, 32'h10);
    access(32'hFFFFFFFC, 3'd3, 1'b0);
    chk("R7", "top byte ok", lim_fault, 1'b0);
    access(32'hFFFFFFFC, 3'd4, 1'b0);
    chk("R7", "carry out", lim_fault, 1'b1);
    @(negedge clk);
    chk("R11", "idle done", acc_done, 1'b0);
    chk("R11", "idle fault", lim_fault | type_fault, 1'b0);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_real();
        t_prot();
        t_gran();
        t_types();
        t_np();
        t_mode();
        t_wrap();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule